// File: doc/BRIEF.md
# Half-Duplex Carrier-Sense Transmit Access Controller

This block decides when a frame assembler may put a frame on a shared or point-to-point medium. It takes a level request from the assembler. In half-duplex mode it waits out any active carrier, enforces the interframe gap and starts the frame. While the frame is being sent it watches the collision input. When a collision is seen, the block replaces the rest of the frame with a jam pattern. Then it waits a random number of slot times and tries again. After too many failed attempts it gives up and reports the frame as dropped. In full-duplex mode the block ignores carrier and collision, and only the interframe gap holds a frame back.

A collision that arrives while the assembler is still sending preamble or the start delimiter does not interrupt them. The block keeps the frame going until the assembler reports that this phase has ended, and only then starts the jam. The jam bits come from a programmable pattern input and are sent least significant bit first, one per bit time. The retry delay is a truncated binary exponential backoff. After the n-th collision the delay is a random whole number of slots from 0 to 2^min(n,BACKOFF_CAP)-1. The random value comes from a 16-bit LFSR that advances on every clock.

The controller is one state machine with these states:
- ST_IDLE: goes to ST_DEFER when a request arrives.
- ST_DEFER: goes to ST_XMIT once the gap is met, and in half-duplex mode only while carrier is low. It goes back to ST_IDLE if the request is withdrawn.
- ST_XMIT: goes to ST_IDLE on frame_done. On a half-duplex collision it goes to ST_PRE_WAIT if the assembler is in the preamble phase, or to ST_JAM otherwise.
- ST_PRE_WAIT: goes to ST_JAM when the preamble phase ends.
- ST_JAM: goes to ST_BACKOFF, or to ST_DROP on the last allowed attempt.
- ST_BACKOFF: goes to ST_DEFER when its timer expires.
- ST_DROP: goes to ST_IDLE when the request falls.

Top module: `csma_tx_ctrl`

## Requirements
- R1: With full_duplex=1 and the gap already satisfied, tx_go rises on the second clock edge after tx_req is raised. This holds whether crs is high or low.
- R2: With full_duplex=0, tx_go never rises while crs is sampled high.
- R3: The gap counter restarts on every clock in which the medium is busy: half-duplex carrier, or any state that sends a frame or a jam. In half-duplex mode, tx_go rises IFG_BITS*CLKS_PER_BIT edges after the first edge that samples crs low. After a transmission ends with a request already pending, tx_go stays low for exactly IFG_BITS*CLKS_PER_BIT+1 clocks.
- R4: A half-duplex collision outside the preamble phase does three things on the next edge: it drops tx_go, it raises tx_jam for JAM_BITS*CLKS_PER_BIT clocks, and it drives jam_bit with jam_pattern[0], jam_pattern[1] and so on, one bit per bit time. tx_go and tx_jam are never high together.
- R5: A half-duplex collision while in_preamble=1 keeps tx_go high and tx_jam low until in_preamble is sampled low. The jam starts on the following clock.
- R6: When the n-th jam ends, attempt_cnt reads n. With crs low, tx_go rises again after between IFG_CLKS+1 and max(IFG_CLKS+1, (2^min(n,BACKOFF_CAP)-1)*SLOT_CLKS+2) clocks.
- R7: When the jam of attempt MAX_ATTEMPTS ends, three things happen: tx_abort pulses for exactly one clock, excess_col goes high, and attempt_cnt reads MAX_ATTEMPTS. No tx_go follows while tx_req stays high.
- R8: With full_duplex=1, col has no effect: tx_jam stays low and tx_go stays high.
- R9: frame_done in ST_XMIT ends the frame on the next clock. A request withdrawn during deferral starts nothing. A new request clears attempt_cnt and excess_col one clock after it is raised.
- R10: After reset, tx_go, tx_jam, jam_bit, tx_abort and excess_col are 0 and attempt_cnt is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| full_duplex | input | 1 | 1 selects full-duplex mode; carrier and collision are then ignored |
| tx_req | input | 1 | Level request from the assembler: a frame is pending |
| crs | input | 1 | Carrier sense |
| col | input | 1 | Collision detect |
| in_preamble | input | 1 | Assembler is sending preamble or start delimiter |
| frame_done | input | 1 | Assembler finished the frame (one-clock pulse) |
| jam_pattern | input | JAM_BITS | Jam bits, sent LSB first |
| tx_go | output | 1 | Assembler may send the frame |
| tx_jam | output | 1 | Jam in progress; the assembler must send jam_bit |
| jam_bit | output | 1 | Current jam bit |
| tx_abort | output | 1 | One-clock pulse when the frame is dropped |
| excess_col | output | 1 | Frame dropped after too many collisions; held until the next request |
| attempt_cnt | output | ATT_W | Collisions counted for the current frame |

## Verification
A gap counter that restarts at the wrong time shows up at tx_go within one frame. The restart timing is visible as a start that comes one clock early or late, measured from carrier drop or from frame end. A jam index that is out of step shows up at jam_bit on the first wrong bit, within 32 clocks. A miscounted attempt shows up on attempt_cnt as soon as the jam ends, and again when the drop comes one attempt early or late. A state machine that leaves the preamble-hold state early raises tx_jam while in_preamble is still high, in the very next clock.

// File: rtl/csma_pkg.sv
package csma_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DEFER,
        ST_XMIT,
        ST_PRE_WAIT,
        ST_JAM,
        ST_BACKOFF,
        ST_DROP
    } tx_state_e;
endpackage

// File: rtl/csma_gap_track.sv
// Counts idle clocks since the medium was last busy, saturating at the gap.
module csma_gap_track #(
    parameter int IFG_CLKS = 96
) (
    input  logic clk,
    input  logic rst_n,
    input  logic busy,
    output logic gap_ok
);
    localparam int CW = $clog2(IFG_CLKS + 1);

    logic [CW-1:0] idle_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idle_cnt <= CW'(IFG_CLKS);
        end else if (busy) begin
            idle_cnt <= '0;
        end else if (idle_cnt != CW'(IFG_CLKS)) begin
            idle_cnt <= idle_cnt + 1'b1;
        end
    end

    assign gap_ok = (idle_cnt == CW'(IFG_CLKS));
endmodule

// File: rtl/csma_backoff_gen.sv
// Free-running LFSR and truncated exponential slot window.
module csma_backoff_gen #(
    parameter int          CAP       = 10,
    parameter int          ATT_W     = 5,
    parameter int          SLOT_CLKS = 512,
    parameter int          BO_W      = 19,
    parameter logic [15:0] SEED      = 16'hACE1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [ATT_W-1:0] coll_n,
    output logic [BO_W-1:0]  wait_clks
);
    logic [15:0]    lfsr_q;
    logic [CAP-1:0] win_mask;
    logic [CAP-1:0] slots;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lfsr_q <= SEED;
        end else begin
            lfsr_q <= {lfsr_q[14:0], lfsr_q[15] ^ lfsr_q[13] ^ lfsr_q[12] ^ lfsr_q[10]};
        end
    end

    for (genvar i = 0; i < CAP; i++) begin : g_mask
        assign win_mask[i] = (int'(coll_n) > i);
    end

    assign slots     = lfsr_q[CAP-1:0] & win_mask;
    assign wait_clks = BO_W'(slots) * BO_W'(SLOT_CLKS);
endmodule

// File: rtl/csma_tx_ctrl.sv
module csma_tx_ctrl #(
    parameter int          CLKS_PER_BIT = 1,
    parameter int          IFG_BITS     = 96,
    parameter int          JAM_BITS     = 32,
    parameter int          SLOT_BITS    = 512,
    parameter int          MAX_ATTEMPTS = 16,
    parameter int          BACKOFF_CAP  = 10,
    parameter logic [15:0] LFSR_SEED    = 16'hACE1,
    localparam int         ATT_W        = $clog2(MAX_ATTEMPTS + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                full_duplex,
    input  logic                tx_req,
    input  logic                crs,
    input  logic                col,
    input  logic                in_preamble,
    input  logic                frame_done,
    input  logic [JAM_BITS-1:0] jam_pattern,
    output logic                tx_go,
    output logic                tx_jam,
    output logic                jam_bit,
    output logic                tx_abort,
    output logic                excess_col,
    output logic [ATT_W-1:0]    attempt_cnt
);
    import csma_pkg::*;

    localparam int IFG_CLKS  = IFG_BITS * CLKS_PER_BIT;
    localparam int SLOT_CLKS = SLOT_BITS * CLKS_PER_BIT;
    localparam int MAX_SLOTS = (1 << BACKOFF_CAP) - 1;
    localparam int BO_W      = $clog2(MAX_SLOTS * SLOT_CLKS + 1);
    localparam int JIDX_W    = $clog2(JAM_BITS);
    localparam int SUB_W     = $clog2(CLKS_PER_BIT + 1);

    tx_state_e         state_q, state_d;
    logic              half_dx;
    logic              busy;
    logic              gap_ok;
    logic [JIDX_W-1:0] jam_idx;
    logic [SUB_W-1:0]  jam_sub;
    logic              jam_last;
    logic [ATT_W-1:0]  att_q;
    logic [ATT_W-1:0]  att_next;
    logic              at_max;
    logic [BO_W-1:0]   bo_tmr;
    logic [BO_W-1:0]   bo_load;
    logic              abort_q;
    logic              excess_q;

    assign half_dx  = !full_duplex;
    assign att_next = att_q + 1'b1;
    assign at_max   = (att_next == ATT_W'(MAX_ATTEMPTS));
    assign jam_last = (jam_idx == JIDX_W'(JAM_BITS - 1)) &&
                      (jam_sub == SUB_W'(CLKS_PER_BIT - 1));
    assign busy     = (half_dx && crs) || (state_q == ST_XMIT) ||
                      (state_q == ST_PRE_WAIT) || (state_q == ST_JAM);

    csma_gap_track #(
        .IFG_CLKS(IFG_CLKS)
    ) u_gap (
        .clk   (clk),
        .rst_n (rst_n),
        .busy  (busy),
        .gap_ok(gap_ok)
    );

    csma_backoff_gen #(
        .CAP      (BACKOFF_CAP),
        .ATT_W    (ATT_W),
        .SLOT_CLKS(SLOT_CLKS),
        .BO_W     (BO_W),
        .SEED     (LFSR_SEED)
    ) u_bo (
        .clk      (clk),
        .rst_n    (rst_n),
        .coll_n   (att_next),
        .wait_clks(bo_load)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:     if (tx_req) state_d = ST_DEFER;
            ST_DEFER: begin
                if (!tx_req)                             state_d = ST_IDLE;
                else if (gap_ok && !(half_dx && crs))    state_d = ST_XMIT;
            end
            ST_XMIT: begin
                if (half_dx && col) state_d = in_preamble ? ST_PRE_WAIT : ST_JAM;
                else if (frame_done) state_d = ST_IDLE;
            end
            ST_PRE_WAIT: if (!in_preamble) state_d = ST_JAM;
            ST_JAM:      if (jam_last) state_d = at_max ? ST_DROP : ST_BACKOFF;
            ST_BACKOFF:  if (bo_tmr == '0) state_d = ST_DEFER;
            ST_DROP:     if (!tx_req) state_d = ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
    end

    // jam bit position
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            jam_idx <= '0;
            jam_sub <= '0;
        end else if (state_q != ST_JAM) begin
            jam_idx <= '0;
            jam_sub <= '0;
        end else if (jam_sub == SUB_W'(CLKS_PER_BIT - 1)) begin
            jam_sub <= '0;
            jam_idx <= jam_idx + 1'b1;
        end else begin
            jam_sub <= jam_sub + 1'b1;
        end
    end

    // attempt bookkeeping, backoff timer, drop status
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            att_q    <= '0;
            excess_q <= 1'b0;
            abort_q  <= 1'b0;
            bo_tmr   <= '0;
        end else begin
            abort_q <= (state_q == ST_JAM) && jam_last && at_max;
            if (state_q == ST_IDLE && tx_req) begin
                att_q    <= '0;
                excess_q <= 1'b0;
            end else if (state_q == ST_JAM && jam_last) begin
                att_q <= att_next;
                if (at_max) excess_q <= 1'b1;
            end
            if (state_q == ST_JAM && jam_last) begin
                bo_tmr <= bo_load;
            end else if (state_q == ST_BACKOFF && bo_tmr != '0) begin
                bo_tmr <= bo_tmr - 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        tx_go       = (state_q == ST_XMIT) || (state_q == ST_PRE_WAIT);
        tx_jam      = (state_q == ST_JAM);
        jam_bit     = (state_q == ST_JAM) ? jam_pattern[jam_idx] : 1'b0;
        tx_abort    = abort_q;
        excess_col  = excess_q;
        attempt_cnt = att_q;
    end
endmodule

// File: rtl/csma_tx_ctrl_chk.sv
module csma_tx_ctrl_chk #(
    parameter int JAM_CLKS     = 32,
    parameter int MAX_ATTEMPTS = 16,
    parameter int ATT_W        = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             full_duplex,
    input logic             crs,
    input logic             col,
    input logic             in_preamble,
    input logic             frame_done,
    input logic             tx_go,
    input logic             tx_jam,
    input logic             tx_abort,
    input logic             excess_col,
    input logic [ATT_W-1:0] attempt_cnt
);
    logic [15:0] jam_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       jam_run <= '0;
        else if (!tx_jam) jam_run <= '0;
        else              jam_run <= jam_run + 1'b1;
    end

    assert_carrier_blocks_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!full_duplex && crs && !tx_go) |=> !tx_go);

    assert_jam_length_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tx_jam) |-> (jam_run == 16'(JAM_CLKS)));

    assert_go_jam_exclusive_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(tx_go && tx_jam));

    assert_preamble_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_go && in_preamble) |=> !tx_jam);

    assert_abort_status_R7: assert property (@(posedge clk) disable iff (!rst_n)
        tx_abort |-> (excess_col && attempt_cnt == ATT_W'(MAX_ATTEMPTS)));

    assert_abort_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        tx_abort |=> !tx_abort);

    assert_fd_col_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (full_duplex && tx_go && col) |=> (tx_go || !tx_jam));

    assert_frame_end_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_go && frame_done && !col && !in_preamble) |=> !tx_go);
endmodule

bind csma_tx_ctrl csma_tx_ctrl_chk #(
    .JAM_CLKS    (JAM_BITS * CLKS_PER_BIT),
    .MAX_ATTEMPTS(MAX_ATTEMPTS),
    .ATT_W       (ATT_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .full_duplex(full_duplex),
    .crs        (crs),
    .col        (col),
    .in_preamble(in_preamble),
    .frame_done (frame_done),
    .tx_go      (tx_go),
    .tx_jam     (tx_jam),
    .tx_abort   (tx_abort),
    .excess_col (excess_col),
    .attempt_cnt(attempt_cnt)
);

// File: tb/tb_csma_tx_ctrl.sv
module tb_csma_tx_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int IFG        = 96;
    localparam int SLOT       = 32;
    localparam int CAP        = 6;
    localparam int MAXA       = 16;
    localparam logic [31:0] PAT = 32'hC3A5_1E96;
    localparam int VEC_N = 6;
    // {full_duplex, carrier-high clocks, expected edges from request to tx_go}
    localparam int VEC [VEC_N][3] = '{
        '{0, 0, 2}, '{0, 1, 98}, '{0, 5, 102}, '{0, 40, 137}, '{1, 10, 2}, '{1, 0, 2}
    };

    logic clk = 0, rst_n = 0;
    logic full_duplex = 0, tx_req = 0, crs = 0, col = 0, in_preamble = 0, frame_done = 0;
    logic [31:0] jam_pattern = PAT;
    logic tx_go, tx_jam, jam_bit, tx_abort, excess_col;
    logic [4:0] attempt_cnt;
    int total = 0, bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    csma_tx_ctrl #(.SLOT_BITS(SLOT), .BACKOFF_CAP(CAP)) dut (
        .clk(clk), .rst_n(rst_n), .full_duplex(full_duplex), .tx_req(tx_req),
        .crs(crs), .col(col), .in_preamble(in_preamble), .frame_done(frame_done),
        .jam_pattern(jam_pattern), .tx_go(tx_go), .tx_jam(tx_jam), .jam_bit(jam_bit),
        .tx_abort(tx_abort), .excess_col(excess_col), .attempt_cnt(attempt_cnt));

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic idle_wait(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic end_frame();
        @(negedge clk); frame_done = 1; tx_req = 0;
        @(negedge clk); frame_done = 0;
        chk(!tx_go, "R9 frame end", tx_go, 0);
    endtask

    task automatic wait_go(output int cyc);
        cyc = 0;
        while (!tx_go && cyc < 5000) begin @(negedge clk); cyc++; end
    endtask

    initial begin
        #(CLK_PERIOD * 190000);
        bad++;
        $display("FAIL watchdog actual=1 expected=0");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int cyc, w, k, hi;
        repeat (3) @(negedge clk);
        chk(tx_go == 0 && tx_jam == 0 && jam_bit == 0, "R10 outputs idle", {tx_go, tx_jam, jam_bit}, 0);
        chk(tx_abort == 0 && excess_col == 0 && attempt_cnt == 0, "R10 status", attempt_cnt, 0);
        rst_n = 1;
        idle_wait(5);

        // R1 R2 R3: start-delay table
        for (int v = 0; v < VEC_N; v++) begin
            full_duplex = VEC[v][0][0];
            tx_req = 1; crs = (VEC[v][1] > 0);
            cyc = 0;
            while (!tx_go && cyc < 1000) begin
                @(negedge clk); cyc++;
                if (cyc == VEC[v][1]) crs = 0;
                if (crs && !full_duplex) chk(!tx_go, "R2 carrier holds", tx_go, 0);
            end
            crs = 0;
            chk(cyc == VEC[v][2], VEC[v][0] ? "R1 full-duplex start" : "R3 gap after carrier", cyc, VEC[v][2]);
            end_frame();
            idle_wait(120);
        end

        // R3: back-to-back gap in full duplex
        full_duplex = 1; tx_req = 1;
        wait_go(cyc);
        @(negedge clk); frame_done = 1;
        @(negedge clk); frame_done = 0;
        w = 0;
        while (!tx_go && w < 1000) begin w++; @(negedge clk); end
        chk(w == IFG + 1, "R3 back-to-back gap", w, IFG + 1);

        // R8: collision ignored in full duplex
        col = 1;
        @(negedge clk); col = 0;
        chk(tx_go && !tx_jam, "R8 col ignored", {tx_go, tx_jam}, 2);
        idle_wait(3);
        chk(tx_go && !tx_jam, "R8 still sending", {tx_go, tx_jam}, 2);
        end_frame();
        idle_wait(120);

        // R5: collision during preamble
        full_duplex = 0; tx_req = 1; in_preamble = 1;
        wait_go(cyc);
        col = 1;
        @(negedge clk); col = 0;
        hi = 1;
        for (int i = 0; i < 5; i++) begin
            if (!tx_go || tx_jam) hi = 0;
            @(negedge clk);
        end
        chk(hi == 1, "R5 preamble completes", hi, 1);
        in_preamble = 0;
        @(negedge clk);
        chk(tx_jam && !tx_go, "R5 jam after preamble", {tx_go, tx_jam}, 1);
        while (tx_jam) @(negedge clk);
        chk(attempt_cnt == 1, "R6 count after preamble jam", attempt_cnt, 1);
        wait_go(cyc);
        end_frame();
        idle_wait(120);

        // R4 R6 R7: repeated data-phase collisions until drop
        tx_req = 1;
        wait_go(cyc);
        for (int n = 1; n <= MAXA; n++) begin
            @(negedge clk); col = 1;
            @(negedge clk); col = 0;
            chk(!tx_go, "R4 go drops", tx_go, 0);
            cyc = 0;
            while (tx_jam && cyc < 100) begin
                if (n == 1) chk(jam_bit == PAT[cyc], "R4 jam bit", jam_bit, PAT[cyc]);
                @(negedge clk); cyc++;
            end
            chk(cyc == 32, "R4 jam length", cyc, 32);
            chk(attempt_cnt == n[4:0], "R6 attempt count", attempt_cnt, n);
            if (n < MAXA) begin
                chk(!tx_abort, "R7 no early abort", tx_abort, 0);
                k = (n < CAP) ? n : CAP;
                w = 0;
                while (!tx_go && w < 5000) begin w++; @(negedge clk); end
                hi = ((1 << k) - 1) * SLOT + 2;
                if (hi < IFG + 1) hi = IFG + 1;
                chk(w >= IFG + 1 && w <= hi, "R6 backoff window", w, hi);
            end else begin
                chk(tx_abort && excess_col, "R7 abort and status", {tx_abort, excess_col}, 3);
                @(negedge clk);
                chk(!tx_abort, "R7 abort one pulse", tx_abort, 0);
                hi = 0;
                for (int i = 0; i < 200; i++) begin
                    if (tx_go) hi = 1;
                    @(negedge clk);
                end
                chk(hi == 0 && excess_col, "R7 no retry after drop", hi, 0);
            end
        end
        tx_req = 0;
        idle_wait(3);
        tx_req = 1;
        @(negedge clk);
        chk(!excess_col && attempt_cnt == 0, "R9 new request clears", attempt_cnt, 0);
        wait_go(cyc);
        end_frame();
        idle_wait(120);

        // R9: request withdrawn while deferring
        crs = 1; tx_req = 1;
        idle_wait(5);
        tx_req = 0;
        idle_wait(2);
        crs = 0;
        hi = 0;
        for (int i = 0; i < 200; i++) begin
            if (tx_go || tx_jam) hi = 1;
            @(negedge clk);
        end
        chk(hi == 0, "R9 withdrawn request", hi, 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule